// File: doc/BRIEF.md
# Crystal Fault Monitor with Clock-Source Fallback

This block watches the health of a low-frequency and a high-frequency crystal oscillator. For each crystal it keeps a sticky fault flag. It also keeps one combined fault flag that software polls or takes an interrupt on. Software clears any of these flags with a one-cycle strobe. A separate enable bit, written with its own strobe, gates a non-maskable interrupt request driven from the combined flag.

The block also sits between the user's source selections for the auxiliary, main and sub-main system clocks and the clock multiplexers that act on them. While a crystal is failing, or while its fault is still latched and the combined flag is pending, any clock selected onto that crystal is redirected to an internal fallback. The low-frequency crystal falls back to the internal low-frequency source. The high-frequency crystal falls back to the internal modulation source, and only on the main and sub-main clocks. The user selections pass through unmodified. Once the combined flag is cleared with no fault left, the effective selections again match them.

Source codes, 3 bits wide: 0 low-frequency crystal, 1 internal low-frequency fallback, 2 internal modulation fallback, 3 high-frequency crystal, 4 digitally controlled oscillator. Codes 5 to 7 pass through unchanged. Power-mode codes 6 and 7 are the two deepest shutdown modes.

Top module: `osc_fault_guard`

## Requirements
- R1: While `rst` is high, at the next clock edge both crystal flags clear, the combined flag sets, the interrupt enable clears, the effective auxiliary source becomes 1 and the effective main and sub-main sources become 2.
- R2: A crystal's flag sets one cycle after a cycle in which its on-indication and fault input are both high. It then stays set after the fault input drops.
- R3: A clear strobe on a crystal flag or on the combined flag clears it at the next edge, unless a detection for that flag occurs in the same cycle. In that case the flag stays set.
- R4: The combined flag sets one cycle after any crystal detection and remains set while any detection persists.
- R5: The interrupt enable changes only on its write strobe. `nmi_req_o` is high exactly when the combined flag and the enable are both high.
- R6: A clock whose user selection is 0 gets effective code 1 while the low-frequency crystal is detected, or while its flag and the combined flag are both set.
- R7: A main or sub-main clock whose user selection is 3 gets effective code 2 while the high-frequency crystal is detected, or while its flag and the combined flag are both set. The auxiliary clock selecting 3 is never redirected.
- R8: When no redirection applies, the effective code equals the user selection. This includes after the combined flag is cleared with no fault remaining.
- R9: In power modes 6 and 7 the high-frequency fault input has no effect. The low-frequency fault logic works in every mode.
- R10: Effective selections are registered and reflect the inputs of the previous cycle.
- R11: A fault input is ignored while its crystal's on-indication is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| lf_on_i | input | 1 | Low-frequency crystal is enabled |
| lf_fault_i | input | 1 | Low-frequency fault condition |
| hf_on_i | input | 1 | High-frequency crystal is enabled |
| hf_fault_i | input | 1 | High-frequency fault condition |
| pwr_mode_i | input | 3 | Current power mode |
| clr_lf_i | input | 1 | Clear strobe, low-frequency flag |
| clr_hf_i | input | 1 | Clear strobe, high-frequency flag |
| clr_comb_i | input | 1 | Clear strobe, combined flag |
| ie_wr_i | input | 1 | Write strobe for interrupt enable |
| ie_wdata_i | input | 1 | Value written to interrupt enable |
| sel_aux_i | input | 3 | User source selection, auxiliary clock |
| sel_main_i | input | 3 | User source selection, main clock |
| sel_sub_i | input | 3 | User source selection, sub-main clock |
| lf_flag_o | output | 1 | Low-frequency fault flag |
| hf_flag_o | output | 1 | High-frequency fault flag |
| comb_flag_o | output | 1 | Combined fault flag |
| ie_o | output | 1 | Interrupt enable |
| nmi_req_o | output | 1 | Non-maskable interrupt request |
| eff_aux_o | output | 3 | Effective auxiliary source |
| eff_main_o | output | 3 | Effective main source |
| eff_sub_o | output | 3 | Effective sub-main source |

## Verification
Every flag is visible at the ports. A flag stuck, lost or wrongly cleared therefore shows on the very next cycle, either in that flag or in `nmi_req_o`. A wrong override state shows one cycle later as an effective source code that differs from what the reference model expects. A clock left on a dead crystal after a fault shows within two cycles of the fault input rising. A clock still redirected after a clean clear shows within two cycles of the clear strobe.

// File: rtl/osc_fault_pkg.sv
package osc_fault_pkg;

    localparam int SEL_W   = 3;
    localparam int PM_W    = 3;
    localparam int NUM_CLK = 3;
    localparam int NUM_OSC = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_LF_XTAL = 3'd0,
        SRC_LF_INT  = 3'd1,
        SRC_MOD_INT = 3'd2,
        SRC_HF_XTAL = 3'd3,
        SRC_DCO     = 3'd4,
        SRC_SPARE5  = 3'd5,
        SRC_SPARE6  = 3'd6,
        SRC_SPARE7  = 3'd7
    } clk_src_e;

    typedef enum int {
        CLK_AUX  = 0,
        CLK_MAIN = 1,
        CLK_SUB  = 2
    } sys_clk_e;

    typedef enum int {
        OSC_LF = 0,
        OSC_HF = 1
    } osc_idx_e;

    localparam logic [PM_W-1:0] PM_SHUT_SHALLOW = 3'd6;
    localparam logic [PM_W-1:0] PM_SHUT_DEEP    = 3'd7;

    typedef struct packed {
        logic hf;
        logic lf;
    } osc_pair_t;

    function automatic logic hf_logic_off(input logic [PM_W-1:0] pm);
        return (pm == PM_SHUT_SHALLOW) || (pm == PM_SHUT_DEEP);
    endfunction

    function automatic clk_src_e reset_source(input int clk_idx);
        return (clk_idx == CLK_AUX) ? SRC_LF_INT : SRC_MOD_INT;
    endfunction

endpackage

// File: rtl/osc_fault_flag.sv
module osc_fault_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= RST_VAL;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R3: a set in the same cycle as a clear wins
    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R2: sticky without a clear
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

    // R11: no spurious set
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/osc_src_override.sv
module osc_src_override
    import osc_fault_pkg::*;
#(
    parameter bit       HF_REDIRECT = 1'b1,
    parameter clk_src_e RST_SRC     = SRC_MOD_INT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] user_sel_i,
    input  logic             lf_bad_i,
    input  logic             hf_bad_i,
    output logic [SEL_W-1:0] eff_o
);
    clk_src_e user_src;
    clk_src_e next_src;
    clk_src_e eff_q;

    assign user_src = clk_src_e'(user_sel_i);

    always_comb begin
        next_src = user_src;
        if (user_src == SRC_LF_XTAL && lf_bad_i)
            next_src = SRC_LF_INT;
        else if (HF_REDIRECT && user_src == SRC_HF_XTAL && hf_bad_i)
            next_src = SRC_MOD_INT;
    end

    always_ff @(posedge clk) begin
        if (rst) eff_q <= RST_SRC;
        else     eff_q <= next_src;
    end

    assign eff_o = eff_q;

    p_lf_fallback_r6: assert property (@(posedge clk) disable iff (rst)
        (user_sel_i == SRC_LF_XTAL && lf_bad_i) |=> (eff_o == SRC_LF_INT));

    p_hf_fallback_r7: assert property (@(posedge clk) disable iff (rst)
        (HF_REDIRECT && user_sel_i == SRC_HF_XTAL && hf_bad_i) |=> (eff_o == SRC_MOD_INT));

    p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
        (!lf_bad_i && !hf_bad_i) |=> (eff_o == $past(user_sel_i)));
endmodule

// File: rtl/osc_fault_guard.sv
module osc_fault_guard
    import osc_fault_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lf_on_i,
    input  logic             lf_fault_i,
    input  logic             hf_on_i,
    input  logic             hf_fault_i,
    input  logic [PM_W-1:0]  pwr_mode_i,
    input  logic             clr_lf_i,
    input  logic             clr_hf_i,
    input  logic             clr_comb_i,
    input  logic             ie_wr_i,
    input  logic             ie_wdata_i,
    input  logic [SEL_W-1:0] sel_aux_i,
    input  logic [SEL_W-1:0] sel_main_i,
    input  logic [SEL_W-1:0] sel_sub_i,
    output logic             lf_flag_o,
    output logic             hf_flag_o,
    output logic             comb_flag_o,
    output logic             ie_o,
    output logic             nmi_req_o,
    output logic [SEL_W-1:0] eff_aux_o,
    output logic [SEL_W-1:0] eff_main_o,
    output logic [SEL_W-1:0] eff_sub_o
);
    osc_pair_t det;
    osc_pair_t flag;
    osc_pair_t bad;
    logic [NUM_OSC-1:0] det_v, clr_v, flag_v;
    logic comb_q;
    logic ie_q;
    logic [NUM_CLK-1:0][SEL_W-1:0] user_sel;
    logic [NUM_CLK-1:0][SEL_W-1:0] eff_sel;

    assign det.lf = lf_on_i & lf_fault_i;
    assign det.hf = hf_on_i & hf_fault_i & ~hf_logic_off(pwr_mode_i);

    assign det_v[OSC_LF] = det.lf;
    assign det_v[OSC_HF] = det.hf;
    assign clr_v[OSC_LF] = clr_lf_i;
    assign clr_v[OSC_HF] = clr_hf_i;

    for (genvar o = 0; o < NUM_OSC; o++) begin : g_osc
        osc_fault_flag #(.RST_VAL(1'b0)) i_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (det_v[o]),
            .clr_i  (clr_v[o]),
            .flag_o (flag_v[o])
        );
    end

    assign flag.lf = flag_v[OSC_LF];
    assign flag.hf = flag_v[OSC_HF];

    osc_fault_flag #(.RST_VAL(1'b1)) i_comb (
        .clk    (clk),
        .rst    (rst),
        .set_i  (|det_v),
        .clr_i  (clr_comb_i),
        .flag_o (comb_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          ie_q <= 1'b0;
        else if (ie_wr_i) ie_q <= ie_wdata_i;
    end

    // a crystal counts as failed while detected, or latched with the combined flag pending
    assign bad.lf = det.lf | (comb_q & flag.lf);
    assign bad.hf = det.hf | (comb_q & flag.hf);

    assign user_sel[CLK_AUX]  = sel_aux_i;
    assign user_sel[CLK_MAIN] = sel_main_i;
    assign user_sel[CLK_SUB]  = sel_sub_i;

    for (genvar c = 0; c < NUM_CLK; c++) begin : g_clk
        osc_src_override #(
            .HF_REDIRECT (c != CLK_AUX),
            .RST_SRC     (reset_source(c))
        ) i_ovr (
            .clk        (clk),
            .rst        (rst),
            .user_sel_i (user_sel[c]),
            .lf_bad_i   (bad.lf),
            .hf_bad_i   (bad.hf),
            .eff_o      (eff_sel[c])
        );
    end

    assign lf_flag_o   = flag.lf;
    assign hf_flag_o   = flag.hf;
    assign comb_flag_o = comb_q;
    assign ie_o        = ie_q;
    assign nmi_req_o   = comb_q & ie_q;
    assign eff_aux_o   = eff_sel[CLK_AUX];
    assign eff_main_o  = eff_sel[CLK_MAIN];
    assign eff_sub_o   = eff_sel[CLK_SUB];

    p_comb_follows_r4: assert property (@(posedge clk) disable iff (rst)
        (lf_on_i && lf_fault_i) |=> comb_flag_o);

    p_deep_hf_off_r9: assert property (@(posedge clk) disable iff (rst)
        (hf_logic_off(pwr_mode_i) && !hf_flag_o) |=> !hf_flag_o);

    p_ie_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ie_wr_i |=> $stable(ie_o));

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (comb_flag_o && !lf_flag_o && !hf_flag_o && !ie_o));
endmodule

// File: tb/test_osc_fault_guard.sv
module test_osc_fault_guard;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lf_on = 0, lf_fault = 0, hf_on = 0, hf_fault = 0;
    logic [2:0] pm = 3'd0;
    logic clr_lf = 0, clr_hf = 0, clr_comb = 0, ie_wr = 0, ie_wd = 0;
    logic [2:0] s_aux = 3'd4, s_main = 3'd4, s_sub = 3'd4;
    logic lf_flag, hf_flag, comb_flag, ie, nmi;
    logic [2:0] e_aux, e_main, e_sub;

    always #2.5 clk = ~clk;

    osc_fault_guard i_osc_fault_guard (
        .clk(clk), .rst(rst),
        .lf_on_i(lf_on), .lf_fault_i(lf_fault),
        .hf_on_i(hf_on), .hf_fault_i(hf_fault),
        .pwr_mode_i(pm),
        .clr_lf_i(clr_lf), .clr_hf_i(clr_hf), .clr_comb_i(clr_comb),
        .ie_wr_i(ie_wr), .ie_wdata_i(ie_wd),
        .sel_aux_i(s_aux), .sel_main_i(s_main), .sel_sub_i(s_sub),
        .lf_flag_o(lf_flag), .hf_flag_o(hf_flag), .comb_flag_o(comb_flag),
        .ie_o(ie), .nmi_req_o(nmi),
        .eff_aux_o(e_aux), .eff_main_o(e_main), .eff_sub_o(e_sub)
    );

    int checks = 0;
    int bad = 0;
    string tag = "R1";
    bit done = 0;

    // behavioural reference
    bit m_lf, m_hf, m_comb, m_ie;
    int m_eff [3];

    function automatic int redirect(int sel, bit lfb, bit hfb, bit hf_ok);
        if (sel == 0 && lfb) return 1;
        if (sel == 3 && hfb && hf_ok) return 2;
        return sel;
    endfunction

    task automatic model_edge();
        bit ldet, hdet, lfb, hfb;
        if (rst) begin
            m_lf = 0; m_hf = 0; m_comb = 1; m_ie = 0;
            m_eff[0] = 1; m_eff[1] = 2; m_eff[2] = 2;
        end else begin
            ldet = lf_on && lf_fault;
            hdet = hf_on && hf_fault && !(pm == 3'd6 || pm == 3'd7);
            lfb = ldet || (m_comb && m_lf);
            hfb = hdet || (m_comb && m_hf);
            m_eff[0] = redirect(int'(s_aux),  lfb, hfb, 0);
            m_eff[1] = redirect(int'(s_main), lfb, hfb, 1);
            m_eff[2] = redirect(int'(s_sub),  lfb, hfb, 1);
            if (ldet) m_lf = 1; else if (clr_lf) m_lf = 0;
            if (hdet) m_hf = 1; else if (clr_hf) m_hf = 0;
            if (ldet || hdet) m_comb = 1; else if (clr_comb) m_comb = 0;
            if (ie_wr) m_ie = ie_wd;
        end
    endtask

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("lf_flag", int'(lf_flag), int'(m_lf));
        check("hf_flag", int'(hf_flag), int'(m_hf));
        check("comb_flag", int'(comb_flag), int'(m_comb));
        check("ie", int'(ie), int'(m_ie));
        check("nmi_req", int'(nmi), int'(m_comb && m_ie));
        check("eff_aux", int'(e_aux), m_eff[0]);
        check("eff_main", int'(e_main), m_eff[1]);
        check("eff_sub", int'(e_sub), m_eff[2]);
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
            clr_lf = 0; clr_hf = 0; clr_comb = 0; ie_wr = 0;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int lcg;
        // R1 reset state
        tag = "R1"; rst = 1; tick(3);
        check("R1 eff_aux reset", int'(e_aux), 1);
        check("R1 comb reset", int'(comb_flag), 1);
        rst = 0;
        // R10/R8 registered pass-through
        tag = "R10"; s_aux = 3'd0; s_main = 3'd3; s_sub = 3'd4; tick(1);
        check("R10 eff_main one cycle later", int'(e_main), 3);
        tag = "R4"; clr_comb = 1; tick(2);
        check("R4 comb cleared with no fault", int'(comb_flag), 0);
        // R11 fault with oscillator off
        tag = "R11"; lf_fault = 1; tick(3);
        check("R11 lf_flag off-osc", int'(lf_flag), 0);
        // R2/R6 LF fault redirects aux and sub
        tag = "R6"; lf_on = 1; s_sub = 3'd0; tick(3);
        check("R6 eff_aux fallback", int'(e_aux), 1);
        check("R6 eff_sub fallback", int'(e_sub), 1);
        tag = "R2"; lf_fault = 0; tick(3);
        check("R2 lf sticky", int'(lf_flag), 1);
        // R3 set beats clear
        tag = "R3"; lf_fault = 1; clr_lf = 1; clr_comb = 1; tick(1);
        check("R3 lf set wins", int'(lf_flag), 1);
        check("R3 comb set wins", int'(comb_flag), 1);
        lf_fault = 0; clr_lf = 1; tick(1);
        check("R3 lf cleared", int'(lf_flag), 0);
        // R8 return after clean combined clear
        tag = "R8"; clr_comb = 1; tick(2);
        check("R8 eff_aux back to user", int'(e_aux), 0);
        // R7 HF fault on main, aux selecting HF untouched
        tag = "R7"; hf_on = 1; hf_fault = 1; s_aux = 3'd3; s_sub = 3'd3; tick(3);
        check("R7 eff_main fallback", int'(e_main), 2);
        check("R7 eff_aux not redirected", int'(e_aux), 3);
        hf_fault = 0; clr_hf = 1; tick(1); clr_comb = 1; tick(2);
        check("R8 eff_main restored", int'(e_main), 3);
        // R9 deepest modes
        tag = "R9"; pm = 3'd6; hf_fault = 1; tick(3);
        check("R9 hf ignored mode6", int'(hf_flag), 0);
        pm = 3'd7; tick(2); lf_fault = 1; s_aux = 3'd0; tick(3);
        check("R9 lf works mode7", int'(lf_flag), 1);
        lf_fault = 0; hf_fault = 0; pm = 0; clr_lf = 1; tick(1); clr_comb = 1; tick(2);
        // R5 enable and request
        tag = "R5"; ie_wr = 1; ie_wd = 1; tick(2);
        check("R5 nmi low without flag", int'(nmi), 0);
        lf_fault = 1; tick(2);
        check("R5 nmi raised", int'(nmi), 1);
        lf_fault = 0; clr_lf = 1; tick(1); clr_comb = 1; tick(2);
        check("R5 ie kept after clear", int'(ie), 1);
        // mixed stimulus
        tag = "R3"; lcg = 12345;
        for (int k = 0; k < 400; k++) begin
            lcg = lcg * 1103515245 + 12345;
            lf_on = lcg[16]; lf_fault = lcg[17]; hf_on = lcg[18]; hf_fault = lcg[19];
            pm = lcg[22:20]; clr_lf = lcg[23]; clr_hf = lcg[24]; clr_comb = lcg[25];
            ie_wr = lcg[26] & lcg[27]; ie_wd = lcg[28];
            s_aux = lcg[10:8]; s_main = lcg[13:11]; s_sub = {1'b0, lcg[15:14]};
            tick(1);
        end
        rst = 1; tag = "R1"; tick(2); rst = 0;
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule